// File: doc/BRIEF.md
# Matrix Keypad Scanning Controller

This block scans a key matrix of up to 16 row lines by 8 column lines, paced by a slow tick enable (a 32 kHz pulse in a typical system). It drives one row line at a time. While a row is driven it samples the column lines, and it only accepts a column reading that stays stable over a programmable debounce window. When a whole pass over the matrix is complete, the block packs the pressed keys into byte-wide key entries. Each entry carries a valid flag, a row number and a column number. The block also keeps the count of valid entries.

Two interrupt sources sit on top of the scan results. The count-threshold interrupt flags a pass that found at least a programmed number of keys. The keypress interrupt, intended for wake, flags a pass that found any key not hidden by the per-row mask registers. A small mode tracker models the move from interrupt mode to continuous polling after a programmed initial delay. It returns to interrupt mode once a programmed residence time has passed with no key, or at once if that residence time is zero. Software reaches everything through a plain word-wide register read/write port.

Top module: `kpd_ctrl`

## Requirements
- R1: After reset every register reads 0, no row line is driven, and both interrupt outputs are low.
- R2: At most one row line is driven at a time, rows are taken in ascending order, and each row stays driven for 16 plus the debounce count tick cycles. After the last row comes a gap of the repeat count plus 5 tick cycles before row 0 is driven again.
- R3: A column bit is accepted only if it holds the same value from the 16th tick of the row slot through the end of the slot. A key that toggles inside that window while the debounce count (control bits 13:4) is nonzero is not reported.
- R4: At the end of a pass, up to 8 pressed keys are reported in row-major order (row ascending, then column ascending). Entry k sits in byte k%4 of the word at 0x14 (k<4) or 0x18 (k>=4). Each entry is {valid at bit 7, row at bits 6:3, column at bits 2:0}, and unused entries read 0. Status bits 7:4 at 0x04 give the entry count.
- R5: Status bit 2 is set at the end of a pass whose entry count is nonzero and at least the threshold (control bits 17:14). It stays set until software writes 1 to bit 2 of 0x04, and writing 0 there has no effect.
- R6: Status bit 0 is set at the end of a pass that found a pressed key whose bit is clear in that row's mask register (0x40 + 4*row, bit = column; only the low 8 bits are stored). It is cleared by writing 1 to bit 0 of 0x04.
- R7: The output irq is high exactly while status bit 2 and control bit 3 are both set. The output wake_irq is high exactly while status bit 0 and control bit 1 are both set.
- R8: With control bit 0 (enable) clear, no row line is driven, and all entries and the entry count read 0 from the next cycle on.
- R9: Status bit 3 (polling) rises once the initial-delay count (0x08, in ticks) has elapsed after the first pass that found a key while in interrupt mode.
- R10: In polling mode, status bit 3 stays set until the timeout count (0x0C) of ticks passes with no pass finding a key. A timeout value of 0 clears status bit 3 on the next cycle.
- R11: After all keys are released and a full pass completes, the entry count and both entry words read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Scan-pace enable, one clock wide per tick |
| col_in | input | 8 | Column sense lines, 1 = key closed on the driven row |
| row_out | output | 16 | Row drive lines, one-hot while a row slot is active |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Register byte address |
| wdata | input | 32 | Register write data |
| rdata | output | 32 | Register read data for addr, combinational |
| irq | output | 1 | Count-threshold interrupt, level |
| wake_irq | output | 1 | Keypress (wake) interrupt, level |

## Verification
The assertions take for granted that col_in reflects only the currently driven row. They also assume that register writes land on whole words at the defined addresses, so a status or entry change can come only from a scan pass or from a write. The bench models the key matrix as a combinational function of row_out, so column data always follows the driven row. It holds tick high to keep passes short, and it writes only the defined addresses with field values inside their widths. Random key sets, debounce counts and repeat gaps are drawn from a fixed seed, and the bench waits two full passes before it compares the entries with its own row-major packing.

// File: rtl/kpd_pkg.sv
package kpd_pkg;
   typedef enum logic [1:0] {PH_IDLE, PH_DLY, PH_ROW, PH_GAP} kpd_phase_e;

   localparam int SCAN_TICKS  = 16;
   localparam int START_TICKS = 5;

   localparam logic [7:0] A_CTRL = 8'h00;
   localparam logic [7:0] A_STAT = 8'h04;
   localparam logic [7:0] A_INIT = 8'h08;
   localparam logic [7:0] A_TMO  = 8'h0C;
   localparam logic [7:0] A_RPT  = 8'h10;
   localparam logic [7:0] A_ENT0 = 8'h14;
   localparam logic [7:0] A_ENT1 = 8'h18;
   localparam logic [7:0] A_MASK = 8'h40;
endpackage

// File: rtl/kpd_scan_seq.sv
module kpd_scan_seq
   import kpd_pkg::*;
#(
   parameter int ROWS = 16,
   parameter int COLS = 8,
   parameter int DEBW = 10,
   parameter int RPTW = 16,
   localparam int RW  = $clog2(ROWS)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            en,
   input  logic            tick,
   input  logic [DEBW-1:0] deb,
   input  logic [RPTW-1:0] rpt,
   input  logic [COLS-1:0] col_in,
   output logic [ROWS-1:0] row_out,
   output logic            row_wr,
   output logic [RW-1:0]   wr_row,
   output logic [COLS-1:0] wr_bits,
   output logic            scan_done
);
   localparam int CW = (((DEBW + 1) > RPTW) ? (DEBW + 1) : RPTW) + 1;

   kpd_phase_e      phase;
   logic [CW-1:0]   cnt, lim;
   logic [RW-1:0]   row;
   logic [COLS-1:0] snap, stab, agree, base;
   logic            first, sampling, slot_end;

   assign lim      = CW'(SCAN_TICKS) + CW'(deb);
   assign first    = (cnt == CW'(SCAN_TICKS - 1));
   assign sampling = (cnt >= CW'(SCAN_TICKS - 1));
   assign slot_end = (cnt == lim - 1'b1);
   assign agree    = first ? '1 : (stab & ~(col_in ^ snap));
   assign base     = first ? col_in : snap;

   for (genvar g = 0; g < ROWS; g++) begin : g_drive
      assign row_out[g] = (phase == PH_ROW) && (row == RW'(g));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase     <= PH_IDLE;
         cnt       <= '0;
         row       <= '0;
         row_wr    <= 1'b0;
         wr_row    <= '0;
         wr_bits   <= '0;
         snap      <= '0;
         stab      <= '0;
         scan_done <= 1'b0;
      end else begin
         row_wr    <= 1'b0;
         scan_done <= row_wr && (wr_row == RW'(ROWS - 1));
         if (!en) begin
            phase     <= PH_IDLE;
            cnt       <= '0;
            row       <= '0;
            scan_done <= 1'b0;
         end else begin
            case (phase)
               PH_IDLE: begin
                  phase <= PH_DLY;
                  cnt   <= '0;
               end
               PH_DLY: if (tick) begin
                  if (cnt == CW'(START_TICKS - 1)) begin
                     phase <= PH_ROW;
                     cnt   <= '0;
                     row   <= '0;
                  end else cnt <= cnt + 1'b1;
               end
               PH_ROW: if (tick) begin
                  if (sampling) begin
                     snap <= base;
                     stab <= agree;
                  end
                  if (slot_end) begin
                     row_wr  <= 1'b1;
                     wr_row  <= row;
                     wr_bits <= base & agree;
                     cnt     <= '0;
                     if (row == RW'(ROWS - 1)) begin
                        row   <= '0;
                        phase <= (rpt == '0) ? PH_DLY : PH_GAP;
                     end else row <= row + 1'b1;
                  end else cnt <= cnt + 1'b1;
               end
               PH_GAP: if (tick) begin
                  if (cnt == CW'(rpt) - 1'b1) begin
                     phase <= PH_DLY;
                     cnt   <= '0;
                  end else cnt <= cnt + 1'b1;
               end
               default: phase <= PH_IDLE;
            endcase
         end
      end
   end
endmodule

// File: rtl/kpd_pack.sv
module kpd_pack #(
   parameter int ROWS    = 16,
   parameter int COLS    = 8,
   parameter int ENTRIES = 8,
   localparam int CNTW   = $clog2(ENTRIES + 1)
) (
   input  logic [ROWS*COLS-1:0]  keymap,
   output logic [ENTRIES*8-1:0]  ents,
   output logic [CNTW-1:0]       count
);
   always_comb begin
      int n;
      n    = 0;
      ents = '0;
      for (int r = 0; r < ROWS; r++) begin
         for (int c = 0; c < COLS; c++) begin
            if (keymap[r*COLS + c] && (n < ENTRIES)) begin
               ents[n*8 +: 8] = {1'b1, 4'(r), 3'(c)};
               n = n + 1;
            end
         end
      end
      count = CNTW'(n);
   end
endmodule

// File: rtl/kpd_mode.sv
module kpd_mode #(
   parameter int IDW = 20,
   parameter int TMW = 16
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           en,
   input  logic           tick,
   input  logic           scan_done,
   input  logic           has_keys,
   input  logic [IDW-1:0] init_dly,
   input  logic [TMW-1:0] tmo,
   output logic           polling
);
   logic           arm;
   logic [IDW-1:0] dcnt;
   logic [TMW-1:0] tcnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         polling <= 1'b0;
         arm     <= 1'b0;
         dcnt    <= '0;
         tcnt    <= '0;
      end else if (!en) begin
         polling <= 1'b0;
         arm     <= 1'b0;
         dcnt    <= '0;
         tcnt    <= '0;
      end else begin
         if (!polling) begin
            if (scan_done && has_keys && !arm) begin
               arm  <= 1'b1;
               dcnt <= '0;
            end else if (arm && tick) begin
               if (dcnt >= init_dly) begin
                  polling <= 1'b1;
                  arm     <= 1'b0;
                  tcnt    <= '0;
               end else dcnt <= dcnt + 1'b1;
            end
         end else if (scan_done && has_keys) begin
            tcnt <= '0;
         end else if (tick) begin
            if (tcnt >= tmo) polling <= 1'b0;
            else tcnt <= tcnt + 1'b1;
         end
         if (tmo == '0) polling <= 1'b0;
      end
   end
endmodule

// File: rtl/kpd_ctrl.sv
module kpd_ctrl
   import kpd_pkg::*;
#(
   parameter int ROWS    = 16,
   parameter int COLS    = 8,
   parameter int ENTRIES = 8,
   parameter int DEBW    = 10,
   parameter int RPTW    = 16,
   parameter int IDW     = 20,
   parameter int TMW     = 16,
   parameter int AW      = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            tick,
   input  logic [COLS-1:0] col_in,
   output logic [ROWS-1:0] row_out,
   input  logic            wr_en,
   input  logic [AW-1:0]   addr,
   input  logic [31:0]     wdata,
   output logic [31:0]     rdata,
   output logic            irq,
   output logic            wake_irq
);
   localparam int RW      = $clog2(ROWS);
   localparam int CNTW    = $clog2(ENTRIES + 1);
   localparam int DEB_LSB = 4;
   localparam int THR_LSB = DEB_LSB + DEBW;

   if (ROWS < 2 || ROWS > 16) begin : g_bad_rows
      $error("ROWS must lie in 2..16");
   end
   if (COLS < 1 || COLS > 8) begin : g_bad_cols
      $error("COLS must lie in 1..8");
   end
   if (ENTRIES < 1 || ENTRIES > 8) begin : g_bad_ent
      $error("ENTRIES must lie in 1..8");
   end
   if (THR_LSB + CNTW > 32 || IDW > 32 || TMW > 32 || RPTW > 32 || AW < 8) begin : g_bad_w
      $error("field widths exceed the register word");
   end

   logic                en_q, kp_en_q, thr_en_q, kp_st, thr_st, pol;
   logic [DEBW-1:0]     deb_q;
   logic [CNTW-1:0]     thr_q, cnt_q, cnt_c;
   logic [RPTW-1:0]     rpt_q;
   logic [IDW-1:0]      init_q;
   logic [TMW-1:0]      tmo_q;
   logic [COLS-1:0]     mask_q [ROWS];
   logic [COLS-1:0]     km     [ROWS];
   logic [ROWS*COLS-1:0] km_flat;
   logic [ENTRIES*8-1:0] ent_q, ent_c;
   logic [63:0]         ent64;
   logic                row_wr, scan_done, kp_hit, in_mask;
   logic [RW-1:0]       wr_row, midx;
   logic [COLS-1:0]     wr_bits;

   wire w_ctrl = wr_en && (addr == AW'(A_CTRL));
   wire w_stat = wr_en && (addr == AW'(A_STAT));

   kpd_scan_seq #(.ROWS(ROWS), .COLS(COLS), .DEBW(DEBW), .RPTW(RPTW)) u_seq (
      .clk(clk), .rst_n(rst_n), .en(en_q), .tick(tick), .deb(deb_q), .rpt(rpt_q),
      .col_in(col_in), .row_out(row_out), .row_wr(row_wr), .wr_row(wr_row),
      .wr_bits(wr_bits), .scan_done(scan_done));

   kpd_pack #(.ROWS(ROWS), .COLS(COLS), .ENTRIES(ENTRIES)) u_pack (
      .keymap(km_flat), .ents(ent_c), .count(cnt_c));

   kpd_mode #(.IDW(IDW), .TMW(TMW)) u_mode (
      .clk(clk), .rst_n(rst_n), .en(en_q), .tick(tick), .scan_done(scan_done),
      .has_keys(cnt_c != '0), .init_dly(init_q), .tmo(tmo_q), .polling(pol));

   assign in_mask = (addr >= AW'(A_MASK)) && (addr < AW'(A_MASK) + AW'(4 * ROWS));
   assign midx    = RW'((addr - AW'(A_MASK)) >> 2);

   for (genvar g = 0; g < ROWS; g++) begin : g_row
      assign km_flat[g*COLS +: COLS] = km[g];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            km[g]     <= '0;
            mask_q[g] <= '0;
         end else begin
            if (!en_q) km[g] <= '0;
            else if (row_wr && (wr_row == RW'(g))) km[g] <= wr_bits;
            if (wr_en && in_mask && (midx == RW'(g))) mask_q[g] <= wdata[COLS-1:0];
         end
      end
   end

   always_comb begin
      kp_hit = 1'b0;
      for (int r = 0; r < ROWS; r++) kp_hit |= |(km[r] & ~mask_q[r]);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q <= 1'b0; kp_en_q <= 1'b0; thr_en_q <= 1'b0;
         deb_q <= '0; thr_q <= '0; rpt_q <= '0; init_q <= '0; tmo_q <= '0;
         kp_st <= 1'b0; thr_st <= 1'b0; ent_q <= '0; cnt_q <= '0;
      end else begin
         if (w_ctrl) begin
            en_q     <= wdata[0];
            kp_en_q  <= wdata[1];
            thr_en_q <= wdata[3];
            deb_q    <= wdata[DEB_LSB +: DEBW];
            thr_q    <= wdata[THR_LSB +: CNTW];
         end
         if (wr_en && addr == AW'(A_RPT))  rpt_q  <= wdata[RPTW-1:0];
         if (wr_en && addr == AW'(A_INIT)) init_q <= wdata[IDW-1:0];
         if (wr_en && addr == AW'(A_TMO))  tmo_q  <= wdata[TMW-1:0];
         if (scan_done && cnt_c != '0 && cnt_c >= thr_q) thr_st <= 1'b1;
         else if (w_stat && wdata[2]) thr_st <= 1'b0;
         if (scan_done && kp_hit) kp_st <= 1'b1;
         else if (w_stat && wdata[0]) kp_st <= 1'b0;
         if (!en_q) begin
            ent_q <= '0;
            cnt_q <= '0;
         end else if (scan_done) begin
            ent_q <= ent_c;
            cnt_q <= cnt_c;
         end
      end
   end

   assign ent64    = 64'(ent_q);
   assign irq      = thr_st && thr_en_q;
   assign wake_irq = kp_st && kp_en_q;

   always_comb begin
      rdata = '0;
      if (addr == AW'(A_CTRL)) begin
         rdata[0] = en_q;
         rdata[1] = kp_en_q;
         rdata[3] = thr_en_q;
         rdata[DEB_LSB +: DEBW] = deb_q;
         rdata[THR_LSB +: CNTW] = thr_q;
      end else if (addr == AW'(A_STAT)) begin
         rdata[0] = kp_st;
         rdata[2] = thr_st;
         rdata[3] = pol;
         rdata[4 +: CNTW] = cnt_q;
      end else if (addr == AW'(A_INIT)) rdata[IDW-1:0]  = init_q;
      else if (addr == AW'(A_TMO))      rdata[TMW-1:0]  = tmo_q;
      else if (addr == AW'(A_RPT))      rdata[RPTW-1:0] = rpt_q;
      else if (addr == AW'(A_ENT0))     rdata = ent64[31:0];
      else if (addr == AW'(A_ENT1))     rdata = ent64[63:32];
      else if (in_mask)                 rdata[COLS-1:0] = mask_q[midx];
   end
endmodule

// File: rtl/kpd_ctrl_chk.sv
module kpd_ctrl_chk #(
   parameter int ROWS    = 16,
   parameter int ENTRIES = 8,
   parameter int CNTW    = 4,
   parameter int TMW     = 16
) (
   input logic            clk,
   input logic            rst_n,
   input logic [ROWS-1:0] row_out,
   input logic            irq,
   input logic            wake_irq,
   input logic            en_q,
   input logic            kp_en_q,
   input logic            thr_en_q,
   input logic [CNTW-1:0] cnt_q,
   input logic            pol,
   input logic [TMW-1:0]  tmo_q
);
   assert_row_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(row_out));

   assert_cnt_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CNTW'(ENTRIES));

   assert_disabled_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !en_q |=> (row_out == '0) && (cnt_q == '0));

   assert_irq_enable_R7: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> thr_en_q);

   assert_wake_enable_R7: assert property (@(posedge clk) disable iff (!rst_n)
      wake_irq |-> kp_en_q);

   assert_timeout_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (tmo_q == '0) |=> !pol);
endmodule

bind kpd_ctrl kpd_ctrl_chk #(.ROWS(ROWS), .ENTRIES(ENTRIES), .CNTW(CNTW), .TMW(TMW)) u_chk (
   .clk(clk), .rst_n(rst_n), .row_out(row_out), .irq(irq), .wake_irq(wake_irq),
   .en_q(en_q), .kp_en_q(kp_en_q), .thr_en_q(thr_en_q), .cnt_q(cnt_q),
   .pol(pol), .tmo_q(tmo_q));

// File: tb/kpd_ctrl_tb.sv
`timescale 1ns/1ps
module kpd_ctrl_tb;
   logic        clk = 1'b0, rst_n = 1'b0, tick = 1'b1, wr_en = 1'b0;
   logic [7:0]  col_in, addr = '0;
   logic [15:0] row_out;
   logic [31:0] wdata = '0, rdata, d;
   logic        irq, wake_irq;
   logic [127:0] keys = '0;
   logic        flick_en = 1'b0, flick_ph = 1'b0;
   int          n_chk = 0, n_fail = 0, cur_deb = 0, cur_rpt = 0;

   always #2 clk = ~clk;
   always @(negedge clk) flick_ph <= ~flick_ph;

   always_comb begin
      col_in = '0;
      for (int r = 0; r < 16; r++)
         if (row_out[r]) col_in |= keys[r*8 +: 8];
      if (flick_en && row_out[5] && flick_ph) col_in[3] = 1'b1;
   end

   kpd_ctrl u_dut (.clk(clk), .rst_n(rst_n), .tick(tick), .col_in(col_in),
      .row_out(row_out), .wr_en(wr_en), .addr(addr), .wdata(wdata),
      .rdata(rdata), .irq(irq), .wake_irq(wake_irq));

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] v);
      @(negedge clk); wr_en = 1'b1; addr = a; wdata = v;
      @(negedge clk); wr_en = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] v);
      @(negedge clk); addr = a; #1; v = rdata;
   endtask

   task automatic settle();
      repeat (2 * (5 + 16 * (16 + cur_deb) + cur_rpt) + 20) @(negedge clk);
   endtask

   function automatic logic [63:0] exp_ent(input logic [127:0] k);
      logic [63:0] e; int n;
      e = '0; n = 0;
      for (int r = 0; r < 16; r++)
         for (int c = 0; c < 8; c++)
            if (k[r*8 + c] && n < 8) begin
               e[n*8 +: 8] = {1'b1, 4'(r), 3'(c)}; n++;
            end
      return e;
   endfunction

   function automatic int exp_cnt(input logic [127:0] k);
      int n; n = 0;
      for (int i = 0; i < 128; i++) if (k[i]) n++;
      return (n > 8) ? 8 : n;
   endfunction

   task automatic check_entries(input string req);
      logic [31:0] e0, e1, s;
      rd(8'h14, e0); rd(8'h18, e1); rd(8'h04, s);
      check(req, {e1, e0}, exp_ent(keys));
      check(req, 64'((s >> 4) & 32'hF), 64'(exp_cnt(keys)));
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      int n;
      void'($urandom(32'h5EED_0011));
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      rd(8'h00, d); check("R1 ctrl", 64'(d), 0);
      rd(8'h04, d); check("R1 stat", 64'(d), 0);
      check("R1 rows/irq", {row_out, irq, wake_irq}, 0);

      // R2 slot length and end-of-pass gap
      cur_deb = 3; cur_rpt = 7;
      wr(8'h10, 7); wr(8'h00, 32'h1 | (3 << 4));
      while (!row_out[0]) @(negedge clk);
      n = 0; while (row_out[0]) begin n++; @(negedge clk); end
      check("R2 slot", 64'(n), 19);
      check("R2 next row", 64'(row_out), 16'h0002);
      while (!row_out[15]) @(negedge clk);
      while (row_out[15]) @(negedge clk);
      n = 0; while (row_out == '0) begin n++; @(negedge clk); end
      check("R2 gap", 64'(n), 12);

      // R4 directed corners
      cur_deb = 0; cur_rpt = 0;
      wr(8'h10, 0); wr(8'h00, 32'h1);
      keys = '0; keys[0] = 1'b1; keys[127] = 1'b1;
      settle(); check_entries("R4 corners");
      keys = '0; keys[9:0] = '1;
      settle(); check_entries("R4 overflow");

      // R4 random key sets, debounce and gap
      for (int t = 0; t < 12; t++) begin
         cur_deb = $urandom_range(0, 3); cur_rpt = $urandom_range(0, 5);
         wr(8'h10, 32'(cur_rpt)); wr(8'h00, 32'h1 | 32'(cur_deb << 4));
         keys = '0;
         for (int i = 0; i < $urandom_range(0, 11); i++) keys[$urandom_range(0, 127)] = 1'b1;
         settle(); check_entries("R4 random");
      end

      // R11 release
      keys = '0; settle(); check_entries("R11 release");

      // R5 / R7 threshold
      cur_deb = 0; cur_rpt = 0; wr(8'h10, 0);
      wr(8'h00, 32'h1 | 32'h8 | (3 << 14)); wr(8'h04, 32'h5);
      keys = '0; keys[3] = 1; keys[20] = 1; settle();
      rd(8'h04, d); check("R5 below", 64'(d[2]), 0); check("R7 irq low", 64'(irq), 0);
      keys[40] = 1; settle();
      rd(8'h04, d); check("R5 reached", 64'(d[2]), 1); check("R7 irq high", 64'(irq), 1);
      wr(8'h04, 32'h0); rd(8'h04, d); check("R5 write0", 64'(d[2]), 1);
      keys = '0; settle();
      rd(8'h04, d); check("R5 sticky", 64'(d[2]), 1);
      wr(8'h00, 32'h1 | (3 << 14)); check("R7 irq gated", 64'(irq), 0);
      wr(8'h04, 32'h4); rd(8'h04, d); check("R5 w1c", 64'(d[2]), 0);

      // R6 / R7 wake masking
      wr(8'h00, 32'h3); keys = '0; keys[2*8 + 4] = 1'b1;
      wr(8'h48, 32'hFFFF_FFFF); wr(8'h04, 32'h1);
      rd(8'h48, d); check("R6 mask width", 64'(d), 32'hFF);
      settle(); rd(8'h04, d);
      check("R6 masked", 64'(d[0]), 0); check("R7 wake low", 64'(wake_irq), 0);
      wr(8'h48, 32'h0); settle(); rd(8'h04, d);
      check("R6 unmasked", 64'(d[0]), 1); check("R7 wake high", 64'(wake_irq), 1);
      wr(8'h00, 32'h1); check("R7 wake gated", 64'(wake_irq), 0);
      wr(8'h04, 32'h1); rd(8'h04, d); check("R6 w1c", 64'(d[0]), 0);

      // R3 debounce rejects a toggling key
      cur_deb = 4; wr(8'h00, 32'h1 | (4 << 4));
      keys = '0; keys[1*8 + 1] = 1'b1; flick_en = 1'b1;
      settle(); check_entries("R3 debounce");
      flick_en = 1'b0;

      // R9 / R10 mode tracking
      cur_deb = 0; wr(8'h00, 32'h0);
      wr(8'h0C, 600); wr(8'h08, 40); keys = '0; keys[3*8 + 2] = 1'b1;
      wr(8'h00, 32'h1);
      n = 0;
      do begin rd(8'h04, d); n++; end while (((d >> 4) & 32'hF) == 0 && n < 2000);
      check("R9 not yet", 64'(d[3]), 0);
      repeat (20) @(negedge clk); rd(8'h04, d); check("R9 waiting", 64'(d[3]), 0);
      repeat (40) @(negedge clk); rd(8'h04, d); check("R9 polling", 64'(d[3]), 1);
      wr(8'h0C, 0); rd(8'h04, d); check("R10 zero forces", 64'(d[3]), 0);
      wr(8'h0C, 600); repeat (700) @(negedge clk);
      rd(8'h04, d); check("R9 rearm", 64'(d[3]), 1);
      keys = '0; repeat (20) @(negedge clk);
      rd(8'h04, d); check("R10 resident", 64'(d[3]), 1);
      repeat (1500) @(negedge clk);
      rd(8'h04, d); check("R10 expired", 64'(d[3]), 0);

      // R8 disable
      keys[0] = 1'b1; settle();
      wr(8'h00, 32'h0); repeat (50) @(negedge clk);
      rd(8'h04, d); check("R8 count", 64'((d >> 4) & 32'hF), 0);
      rd(8'h14, d); check("R8 entries", 64'(d), 0);
      check("R8 rows", 64'(row_out), 0);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule